// File: doc/BRIEF.md
# Machine Status Register Write Controller

This block owns the 64-bit machine status register of a processor core that has hypervisor support. When a write is accepted, it filters the new value and stores it. The filter applies the writable-bits mask, protects the hypervisor bit, and forces the translation and interrupt-enable bits while in problem state. From the stored value it derives the instruction-side and data-side 3-bit memory-mode indices and a cached set of execution flags. It also outputs the exception vector prefix.

A write can also trigger side effects, each raised as a registered output:

- a one-cycle pipeline-flush request when the translation context changes;
- a one-cycle strobe that tells the register file to swap its first four general registers with four shadow registers;
- a halt request that stays high until an interrupt becomes pending.

The mode-index encoding is chosen per write by a configuration input, either server or embedded. All bit positions, the writable mask, the flag mask and the reset value are parameters. The values quoted below are the defaults.

Top module: `psr_write_ctrl`

## Requirements
- R1: An accepted write stores only the bits of the write mask (default 0x9000_0000_1206_E071). Bits outside the mask read 0 on `psr_q` from the cycle after the write.
- R2: The hypervisor bit (bit 60) takes the written value only when `wr_hv_ok` is 1 and the current bit 60 is 1. Otherwise it keeps its value. Reset loads only bit 60 (0x1000_0000_0000_0000).
- R3: When `cfg_seg64` is 1 and the filtered value has the problem-state bit (bit 14) set, bits 15, 5 and 4 are stored as 1.
- R4: `flush_req` is high for exactly the cycle after a write whose stored bit 5 or bit 4 differs from the old value. With `cfg_embedded` = 1, a change of the guest bit (bit 28) also raises it.
- R5: `gpr_swap` is high for exactly the cycle after a write that toggles bit 17 while `cfg_shadow_en` is 1.
- R6: `excp_prefix` is 0xFFF0_0000 while `psr_q` bit 6 is 1, and 0 otherwise.
- R7: In server encoding (`cfg_embedded` = 0), each index is the sum of three terms:
  - 0 if bit 14 is set, else 1;
  - plus 2 if its translate bit is clear (bit 5 for instruction, bit 4 for data);
  - plus 4 if bit 60 is set.
- R8: In embedded encoding, each index is the sum of three terms:
  - 0 if bit 14 is set, else 1;
  - plus 2 if its address-space bit is set (bit 5 for instruction, bit 4 for data);
  - plus 4 if bit 28 is set.
- R9: On a write, `exec_flags` becomes the stored value ANDed with 0x9000_0000_0200_6031, ORed with `ext_flags` as sampled at that write.
- R10: `halt_req` rises in the cycle after a write that stores bit 18 = 1 while `irq_pending` is 0 and `pow_ok` is 1. It then stays high.
- R11: `irq_pending` clears `halt_req` in the next cycle and blocks it from being set. Reset clears the indices, the flags, the pulses and `halt_req`.
- R12: In a cycle without a write, the register, the indices and the flags hold, and no flush or swap pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write accepted this cycle |
| wr_value | input | 64 | Value to write |
| wr_hv_ok | input | 1 | Write may alter the hypervisor bit |
| cfg_embedded | input | 1 | 1 selects embedded mode-index encoding |
| cfg_seg64 | input | 1 | 64-bit server rule: problem state forces bits 15, 5, 4 |
| cfg_shadow_en | input | 1 | Shadow general-register support present |
| ext_flags | input | 64 | Flags merged into the cached flags on a write |
| irq_pending | input | 1 | An interrupt is pending |
| pow_ok | input | 1 | Power-save entry permitted |
| psr_q | output | 64 | Current register value |
| imode_idx | output | 3 | Instruction-side memory-mode index |
| dmode_idx | output | 3 | Data-side memory-mode index |
| exec_flags | output | 64 | Cached execution flags |
| flush_req | output | 1 | One-cycle pipeline-flush request |
| gpr_swap | output | 1 | One-cycle shadow-register swap strobe |
| halt_req | output | 1 | Halt request |
| excp_prefix | output | 64 | Exception vector prefix |

## Verification
Two pairs of functions can fall on the same write.

The first pair is the flush pulse and the swap strobe. A single write that flips a translate bit and the temporary-register bit together provokes both. The bench then expects both pulses high in the same following cycle.

The second pair is halt entry and the interrupt clear. A write that sets the power-save bit while `irq_pending` is high provokes the overlap. The expected result is that halt stays low.

The behavioural reference model predicts every output on every clock, so each overlap is judged against it in the cycle it occurs.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;
   typedef enum logic {
      ENC_SERVER = 1'b0,
      ENC_EMBED  = 1'b1
   } mode_enc_e;

   localparam int IDX_W = 3;

   function automatic logic [IDX_W-1:0] build_idx(input logic base,
                                                  input logic mid,
                                                  input logic top);
      return {top, mid, base};
   endfunction
endpackage

// File: rtl/psr_write_filter.sv
`timescale 1ns/1ps
module psr_write_filter #(
   parameter int          DATA_W  = 64,
   parameter logic [63:0] WR_MASK = 64'h9000_0000_1206_E071,
   parameter int          HV_BIT  = 60,
   parameter int          PR_BIT  = 14,
   parameter int          EE_BIT  = 15,
   parameter int          IR_BIT  = 5,
   parameter int          DR_BIT  = 4
) (
   input  logic [DATA_W-1:0] wr_value,
   input  logic              cur_hv,
   input  logic              hv_ok,
   input  logic              seg64,
   output logic [DATA_W-1:0] nxt_value
);
   localparam logic [DATA_W-1:0] MASK_W = WR_MASK[DATA_W-1:0];

   logic [DATA_W-1:0] masked;
   logic [DATA_W-1:0] protect;

   always_comb begin
      masked = wr_value & MASK_W;
   end

   always_comb begin
      protect = masked;
      if (!(hv_ok && cur_hv)) begin
         protect[HV_BIT] = cur_hv;
      end
   end

   always_comb begin
      nxt_value = protect;
      if (seg64 && protect[PR_BIT]) begin
         nxt_value[EE_BIT] = 1'b1;
         nxt_value[IR_BIT] = 1'b1;
         nxt_value[DR_BIT] = 1'b1;
      end
   end
endmodule

// File: rtl/psr_mode_index.sv
`timescale 1ns/1ps
module psr_mode_index #(
   parameter bit EMBED_EN = 1'b1
) (
   input  logic       embedded,
   input  logic       pr,
   input  logic       hv,
   input  logic       gs,
   input  logic [1:0] xlat,
   input  logic [1:0] aspace,
   output logic [2:0] iidx,
   output logic [2:0] didx
);
   import psr_pkg::*;

   mode_enc_e  enc;
   logic [2:0] side_idx [2];

   generate
      if (EMBED_EN) begin : g_sel_cfg
         assign enc = embedded ? ENC_EMBED : ENC_SERVER;
      end else begin : g_sel_server
         logic unused_emb;
         assign unused_emb = embedded;
         assign enc = ENC_SERVER;
      end
   endgenerate

   generate
      for (genvar s = 0; s < 2; s++) begin : g_side
         logic mid_b;
         logic top_b;
         always_comb begin
            if (enc == ENC_EMBED) begin
               mid_b = aspace[s];
               top_b = gs;
            end else begin
               mid_b = !xlat[s];
               top_b = hv;
            end
            side_idx[s] = build_idx(!pr, mid_b, top_b);
         end
      end
   endgenerate

   assign iidx = side_idx[1];
   assign didx = side_idx[0];
endmodule

// File: rtl/psr_side_effects.sv
`timescale 1ns/1ps
module psr_side_effects (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_valid,
   input  logic       embedded,
   input  logic       shadow_en,
   input  logic       irq_pending,
   input  logic       pow_ok,
   input  logic [1:0] cur_xlat,
   input  logic [1:0] nxt_xlat,
   input  logic       cur_gs,
   input  logic       nxt_gs,
   input  logic       cur_tg,
   input  logic       nxt_tg,
   input  logic       nxt_pow,
   output logic       flush_q,
   output logic       swap_q,
   output logic       halt_q
);
   logic xlat_chg;
   logic gs_chg;
   logic halt_set;

   assign xlat_chg = |(cur_xlat ^ nxt_xlat);
   assign gs_chg   = embedded && (cur_gs != nxt_gs);
   assign halt_set = wr_valid && nxt_pow && !irq_pending && pow_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_q <= 1'b0;
         swap_q  <= 1'b0;
      end else begin
         flush_q <= wr_valid && (xlat_chg || gs_chg);
         swap_q  <= wr_valid && shadow_en && (cur_tg != nxt_tg);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
      end else if (halt_set) begin
         halt_q <= 1'b1;
      end else if (irq_pending) begin
         halt_q <= 1'b0;
      end
   end

   AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q |-> $past(wr_valid)); // R4
   AST_SWAP_NEEDS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      swap_q |-> ($past(shadow_en) && $past(wr_valid))); // R5
   AST_IRQ_DROPS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pending |=> !halt_q); // R11
   AST_HALT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_q) |-> ($past(pow_ok) && $past(wr_valid))); // R10
endmodule

// File: rtl/psr_write_ctrl.sv
`timescale 1ns/1ps
module psr_write_ctrl #(
   parameter int          DATA_W     = 64,
   parameter logic [63:0] WR_MASK    = 64'h9000_0000_1206_E071,
   parameter logic [63:0] FLAG_MASK  = 64'h9000_0000_0200_6031,
   parameter logic [63:0] RST_VALUE  = 64'h1000_0000_0000_0000,
   parameter logic [63:0] PREFIX_VAL = 64'h0000_0000_FFF0_0000,
   parameter bit          EMBED_EN   = 1'b1,
   parameter int          HV_BIT     = 60,
   parameter int          GS_BIT     = 28,
   parameter int          POW_BIT    = 18,
   parameter int          TG_BIT     = 17,
   parameter int          EE_BIT     = 15,
   parameter int          PR_BIT     = 14,
   parameter int          EP_BIT     = 6,
   parameter int          IR_BIT     = 5,
   parameter int          DR_BIT     = 4,
   parameter int          IS_BIT     = 5,
   parameter int          DS_BIT     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_value,
   input  logic              wr_hv_ok,
   input  logic              cfg_embedded,
   input  logic              cfg_seg64,
   input  logic              cfg_shadow_en,
   input  logic [DATA_W-1:0] ext_flags,
   input  logic              irq_pending,
   input  logic              pow_ok,
   output logic [DATA_W-1:0] psr_q,
   output logic [2:0]        imode_idx,
   output logic [2:0]        dmode_idx,
   output logic [DATA_W-1:0] exec_flags,
   output logic              flush_req,
   output logic              gpr_swap,
   output logic              halt_req,
   output logic [DATA_W-1:0] excp_prefix
);
   localparam logic [DATA_W-1:0] MASK_W  = WR_MASK[DATA_W-1:0];
   localparam logic [DATA_W-1:0] FMASK_W = FLAG_MASK[DATA_W-1:0];
   localparam logic [DATA_W-1:0] RST_W   = RST_VALUE[DATA_W-1:0];
   localparam logic [DATA_W-1:0] PFX_W   = PREFIX_VAL[DATA_W-1:0];
   localparam int MAX_BIT = (HV_BIT > GS_BIT) ? HV_BIT : GS_BIT;

   generate
      if (DATA_W < 32 || DATA_W > 64 || MAX_BIT >= DATA_W) begin : g_bad_width
         $fatal(1, "psr_write_ctrl: DATA_W out of range for bit map");
      end
      if (!MASK_W[EE_BIT] || !MASK_W[IR_BIT] || !MASK_W[DR_BIT]) begin : g_bad_force
         $fatal(1, "psr_write_ctrl: forced bits must be writable");
      end
      if ((RST_W & ~MASK_W) != '0) begin : g_bad_reset
         $fatal(1, "psr_write_ctrl: reset value outside writable mask");
      end
   endgenerate

   logic [DATA_W-1:0] nxt_value;
   logic [2:0]        nxt_iidx;
   logic [2:0]        nxt_didx;

   psr_write_filter #(
      .DATA_W (DATA_W),
      .WR_MASK(WR_MASK),
      .HV_BIT (HV_BIT),
      .PR_BIT (PR_BIT),
      .EE_BIT (EE_BIT),
      .IR_BIT (IR_BIT),
      .DR_BIT (DR_BIT)
   ) u_filter (
      .wr_value (wr_value),
      .cur_hv   (psr_q[HV_BIT]),
      .hv_ok    (wr_hv_ok),
      .seg64    (cfg_seg64),
      .nxt_value(nxt_value)
   );

   psr_mode_index #(
      .EMBED_EN(EMBED_EN)
   ) u_mode (
      .embedded(cfg_embedded),
      .pr      (nxt_value[PR_BIT]),
      .hv      (nxt_value[HV_BIT]),
      .gs      (nxt_value[GS_BIT]),
      .xlat    ({nxt_value[IR_BIT], nxt_value[DR_BIT]}),
      .aspace  ({nxt_value[IS_BIT], nxt_value[DS_BIT]}),
      .iidx    (nxt_iidx),
      .didx    (nxt_didx)
   );

   psr_side_effects u_fx (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (wr_valid),
      .embedded   (cfg_embedded),
      .shadow_en  (cfg_shadow_en),
      .irq_pending(irq_pending),
      .pow_ok     (pow_ok),
      .cur_xlat   ({psr_q[IR_BIT], psr_q[DR_BIT]}),
      .nxt_xlat   ({nxt_value[IR_BIT], nxt_value[DR_BIT]}),
      .cur_gs     (psr_q[GS_BIT]),
      .nxt_gs     (nxt_value[GS_BIT]),
      .cur_tg     (psr_q[TG_BIT]),
      .nxt_tg     (nxt_value[TG_BIT]),
      .nxt_pow    (nxt_value[POW_BIT]),
      .flush_q    (flush_req),
      .swap_q     (gpr_swap),
      .halt_q     (halt_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psr_q      <= RST_W;
         imode_idx  <= '0;
         dmode_idx  <= '0;
         exec_flags <= '0;
      end else if (wr_valid) begin
         psr_q      <= nxt_value;
         imode_idx  <= nxt_iidx;
         dmode_idx  <= nxt_didx;
         exec_flags <= (nxt_value & FMASK_W) | ext_flags;
      end
   end

   assign excp_prefix = psr_q[EP_BIT] ? PFX_W : '0;

   AST_MASKED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (psr_q & ~MASK_W) == '0); // R1
   AST_HV_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !(wr_hv_ok && psr_q[HV_BIT])) |=> $stable(psr_q[HV_BIT])); // R2
   AST_PR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && cfg_seg64) |=>
         (!psr_q[PR_BIT] || (psr_q[EE_BIT] && psr_q[IR_BIT] && psr_q[DR_BIT]))); // R3
   AST_IDX_PRIV_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> (imode_idx[0] == !psr_q[PR_BIT] && dmode_idx[0] == !psr_q[PR_BIT])); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> ($stable(psr_q) && $stable(exec_flags) && !flush_req && !gpr_swap)); // R12
endmodule

// File: tb/psr_write_ctrl_bench.sv
`timescale 1ns/1ps
module psr_write_ctrl_bench;
   localparam logic [63:0] WMASK = 64'h9000_0000_1206_E071;
   localparam logic [63:0] FMASK = 64'h9000_0000_0200_6031;
   localparam logic [63:0] RSTV  = 64'h1000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [63:0] wr_value = '0;
   logic        wr_hv_ok = 1'b0;
   logic        cfg_embedded = 1'b0;
   logic        cfg_seg64 = 1'b0;
   logic        cfg_shadow_en = 1'b0;
   logic [63:0] ext_flags = '0;
   logic        irq_pending = 1'b0;
   logic        pow_ok = 1'b0;
   logic [63:0] psr_q;
   logic [2:0]  imode_idx;
   logic [2:0]  dmode_idx;
   logic [63:0] exec_flags;
   logic        flush_req;
   logic        gpr_swap;
   logic        halt_req;
   logic [63:0] excp_prefix;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   psr_write_ctrl u_psr_write_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_value(wr_value),
      .wr_hv_ok(wr_hv_ok), .cfg_embedded(cfg_embedded), .cfg_seg64(cfg_seg64),
      .cfg_shadow_en(cfg_shadow_en), .ext_flags(ext_flags),
      .irq_pending(irq_pending), .pow_ok(pow_ok), .psr_q(psr_q),
      .imode_idx(imode_idx), .dmode_idx(dmode_idx), .exec_flags(exec_flags),
      .flush_req(flush_req), .gpr_swap(gpr_swap), .halt_req(halt_req),
      .excp_prefix(excp_prefix)
   );

   // reference model state
   logic [63:0] m_psr = RSTV;
   logic [63:0] m_flags = '0;
   int          m_i = 0;
   int          m_d = 0;
   bit          m_flush = 0;
   bit          m_swap = 0;
   bit          m_halt = 0;
   bit          m_emb = 0;
   logic [63:0] mv;

   function automatic int idx_of(input logic [63:0] v, input bit emb, input bit instr);
      int r;
      int pos;
      pos = instr ? 5 : 4;
      r = v[14] ? 0 : 1;
      if (emb) begin
         if (v[pos]) r += 2;
         if (v[28]) r += 4;
      end else begin
         if (!v[pos]) r += 2;
         if (v[60]) r += 4;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_psr = RSTV; m_flags = '0; m_i = 0; m_d = 0;
         m_flush = 0; m_swap = 0; m_halt = 0;
      end else begin
         m_flush = 0;
         m_swap = 0;
         if (irq_pending) m_halt = 0;
         if (wr_valid) begin
            mv = wr_value & WMASK;
            if (!(wr_hv_ok && m_psr[60])) mv[60] = m_psr[60];
            if (cfg_seg64 && mv[14]) begin
               mv[15] = 1'b1; mv[5] = 1'b1; mv[4] = 1'b1;
            end
            m_flush = (mv[5] != m_psr[5]) || (mv[4] != m_psr[4]) ||
                      (cfg_embedded && (mv[28] != m_psr[28]));
            m_swap = cfg_shadow_en && (mv[17] != m_psr[17]);
            m_i = idx_of(mv, cfg_embedded, 1'b1);
            m_d = idx_of(mv, cfg_embedded, 1'b0);
            m_emb = cfg_embedded;
            m_flags = (mv & FMASK) | ext_flags;
            if (mv[18] && !irq_pending && pow_ok) m_halt = 1;
            m_psr = mv;
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
      end
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 register value", psr_q, m_psr);
         check(m_emb ? "R8 instr index" : "R7 instr index", {61'd0, imode_idx}, 64'(m_i));
         check(m_emb ? "R8 data index" : "R7 data index", {61'd0, dmode_idx}, 64'(m_d));
         check("R9 flags", exec_flags, m_flags);
         check("R4 flush", {63'd0, flush_req}, {63'd0, m_flush});
         check("R5 swap", {63'd0, gpr_swap}, {63'd0, m_swap});
         check("R10 halt", {63'd0, halt_req}, {63'd0, m_halt});
         check("R6 prefix", excp_prefix, m_psr[6] ? 64'h0000_0000_FFF0_0000 : 64'd0);
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [63:0] v, input bit hv);
      wr_valid = 1'b1; wr_value = v; wr_hv_ok = hv;
      step();
      wr_valid = 1'b0; wr_value = {$urandom, $urandom};
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step(); step();
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [63:0] held;
      step(); step();
      #1;
      // R11 reset state (R2 reset value)
      check("R11 reset index", {58'd0, imode_idx, dmode_idx}, 64'd0);
      check("R11 reset halt/pulses", {61'd0, halt_req, flush_req, gpr_swap}, 64'd0);
      check("R2 reset value", psr_q, RSTV);
      rst_n = 1'b1;
      step();

      // R2: no permission, hv bit must hold
      wr(64'hFFFF_FFFF_FFFF_FFFF & ~(64'd1 << 60), 1'b0);
      #1 check("R2 hv kept without permission", {63'd0, psr_q[60]}, 64'd1);
      check("R1 unwritable bits zero", psr_q & ~WMASK, 64'd0);
      // R2: permission and current set -> cleared
      step();
      wr(64'd0, 1'b1);
      #1 check("R2 hv cleared with permission", {63'd0, psr_q[60]}, 64'd0);
      step();
      wr(64'd1 << 60, 1'b1);
      #1 check("R2 hv cannot be set when clear", {63'd0, psr_q[60]}, 64'd0);
      step();

      // R3 problem-state forcing
      cfg_seg64 = 1'b1;
      wr(64'd1 << 14, 1'b0);
      #1 check("R3 forced bits", psr_q & 64'hC030, 64'hC030);
      cfg_seg64 = 1'b0;
      step();
      wr(64'd1 << 14, 1'b0);
      #1 check("R3 no forcing when disabled", psr_q & 64'hC030, 64'h4000);
      step();

      // R4 + R5 in the same write
      cfg_shadow_en = 1'b1;
      wr((64'd1 << 17) | (64'd1 << 5), 1'b0);
      #1 check("R4 flush with swap", {63'd0, flush_req}, 64'd1);
      check("R5 swap with flush", {63'd0, gpr_swap}, 64'd1);
      step();
      check("R4 flush lasts one cycle", {63'd0, flush_req}, 64'd0);

      // R4 guest bit in embedded mode, R8 index
      cfg_embedded = 1'b1;
      wr((64'd1 << 17) | (64'd1 << 5) | (64'd1 << 28), 1'b0);
      #1 check("R4 guest change flushes", {63'd0, flush_req}, 64'd1);
      check("R8 embedded instr index", {61'd0, imode_idx}, 64'd7);
      step();
      cfg_embedded = 1'b0;

      // R6 prefix
      wr(64'd1 << 6, 1'b0);
      #1 check("R6 prefix set", excp_prefix, 64'h0000_0000_FFF0_0000);
      step();

      // R10 halt blocked by pending interrupt in the same write
      pow_ok = 1'b1; irq_pending = 1'b1;
      wr(64'd1 << 18, 1'b0);
      #1 check("R11 irq blocks halt", {63'd0, halt_req}, 64'd0);
      irq_pending = 1'b0;
      step();
      wr(64'd1 << 18, 1'b0);
      #1 check("R10 halt set", {63'd0, halt_req}, 64'd1);
      step(); step();
      check("R10 halt held", {63'd0, halt_req}, 64'd1);
      irq_pending = 1'b1;
      step();
      check("R11 irq clears halt", {63'd0, halt_req}, 64'd0);
      irq_pending = 1'b0;

      // R12 idle holds
      ext_flags = 64'hFFFF_0000_0000_0000;
      held = psr_q;
      for (int k = 0; k < 4; k++) begin
         wr_value = {$urandom, $urandom};
         step();
      end
      check("R12 idle register hold", psr_q, held);
      check("R12 idle no pulse", {62'd0, flush_req, gpr_swap}, 64'd0);

      // random phase
      for (int c = 0; c < 4000; c++) begin
         if (c % 500 == 499) begin
            do_reset();
         end else begin
            wr_valid      = ($urandom % 4) != 0;
            wr_value      = {$urandom, $urandom};
            wr_hv_ok      = $urandom % 2;
            cfg_embedded  = ($urandom % 8) == 0 ? ~cfg_embedded : cfg_embedded;
            cfg_seg64     = $urandom % 2;
            cfg_shadow_en = $urandom % 2;
            ext_flags     = {$urandom, $urandom} & 64'h0000_00FF_0000_FF00;
            irq_pending   = ($urandom % 8) == 0;
            pow_ok        = $urandom % 2;
            step();
         end
      end
      wr_valid = 1'b0;
      step(); step();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule